// File: doc/BRIEF.md
# DMA Descriptor Status Tracker

This block keeps the bookkeeping flags for a small set of DMA transfer descriptors in a controller programmed by software. Each descriptor carries two coupled bits: a free bit, which says software may write a new configuration into the descriptor, and a finished bit, which says the last transfer on that descriptor has ended. Software arms a descriptor through a write strobe with a bit mask. The transfer engine later reports the end of that transfer, either successful or failed, with a one-cycle pulse. Software acknowledges the end through a write-one-to-clear strobe.

Both flag vectors are packed into one status word for readback. Each finished bit, gated by a per-descriptor enable input, drives a transfer interrupt line. The OR of those lines forms a combined interrupt. The register bus decode is reduced to plain strobe and data ports.

Top module: `dma_desc_status`

## Requirements
- R1: While `rst_n` is low and after its release, `status` reads 8'h0F: every free bit is 1 and every finished bit is 0. All interrupt outputs are 0.
- R2: `status[3:0]` holds the free bits and `status[7:4]` holds the finished bits. Descriptor n sits at offset n in each group.
- R3: A cycle with `arm_we` high and `arm_mask[n]` = 1 clears descriptor n's free bit and its finished bit at the next clock edge. Mask bits at 0 leave their descriptor unchanged.
- R4: A `xfer_done[n]` or `xfer_err[n]` pulse sets both the free bit and the finished bit of descriptor n at the next clock edge. The two kinds of ending behave the same.
- R5: A cycle with `ack_we` high and `ack_mask[n]` = 1 clears descriptor n's finished bit at the next edge. It leaves the free bit unchanged. Mask bits at 0 have no effect.
- R6: A done or error pulse for descriptor n in the same cycle as an arm or acknowledge of n wins. Both of n's flags are 1 after that edge.
- R7: With no strobe high and no done or error pulse, every flag keeps its value. Mask data presented while its strobe is low has no effect.
- R8: `xfer_irq[n]` equals descriptor n's finished bit ANDed with `irq_en[n]`, with no added latency.
- R9: `irq_any` is the OR of the four `xfer_irq` lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_we | input | 1 | Write strobe for the descriptor arm mask |
| arm_mask | input | 4 | Descriptors to arm, one bit each |
| ack_we | input | 1 | Write strobe for the interrupt acknowledge mask |
| ack_mask | input | 4 | Descriptors whose finished bit is cleared |
| xfer_done | input | 4 | Successful-end pulse per descriptor |
| xfer_err | input | 4 | Failed-end pulse per descriptor |
| irq_en | input | 4 | Per-descriptor interrupt enable |
| status | output | 8 | {finished bits, free bits} |
| xfer_irq | output | 4 | Per-descriptor transfer interrupt |
| irq_any | output | 1 | OR of all transfer interrupts |

## Verification
The bench targets cycles where an ending pulse from the engine meets a software arm or acknowledge on the same descriptor. A sweep first puts every descriptor into each reachable flag state. It then applies all sixteen combinations of done, error, arm and acknowledge to one descriptor at a time, so each collision happens from each starting state. A long pseudo-random run mixes all strobes and masks, including masks presented with their strobe low. The status word and interrupts are compared after every edge against flags the bench computes from the priority rule.

// File: rtl/dma_desc_status.sv
module dma_desc_status #(
  parameter int NDESC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_we,
  input  logic [NDESC-1:0]   arm_mask,
  input  logic               ack_we,
  input  logic [NDESC-1:0]   ack_mask,
  input  logic [NDESC-1:0]   xfer_done,
  input  logic [NDESC-1:0]   xfer_err,
  input  logic [NDESC-1:0]   irq_en,
  output logic [2*NDESC-1:0] status,
  output logic [NDESC-1:0]   xfer_irq,
  output logic               irq_any
);

  logic [NDESC-1:0] free_q, fin_q;
  logic [NDESC-1:0] ends, arms, acks;

  assign ends = xfer_done | xfer_err;
  assign arms = arm_we ? arm_mask : '0;
  assign acks = ack_we ? ack_mask : '0;

  for (genvar i = 0; i < NDESC; i++) begin : g_desc
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        free_q[i] <= 1'b1;
        fin_q[i]  <= 1'b0;
      end else if (ends[i]) begin
        free_q[i] <= 1'b1;
        fin_q[i]  <= 1'b1;
      end else begin
        if (arms[i]) free_q[i] <= 1'b0;
        if (arms[i] || acks[i]) fin_q[i] <= 1'b0;
      end
    end
  end

  assign status   = {fin_q, free_q};
  assign xfer_irq = fin_q & irq_en;
  assign irq_any  = |xfer_irq;

endmodule

module dma_desc_status_chk #(
  parameter int NDESC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm_we,
  input logic [NDESC-1:0]   arm_mask,
  input logic               ack_we,
  input logic [NDESC-1:0]   ack_mask,
  input logic [NDESC-1:0]   xfer_done,
  input logic [NDESC-1:0]   xfer_err,
  input logic [2*NDESC-1:0] status
);
  logic [NDESC-1:0] ev, arm_only, ack_only, fr, fn;
  assign ev       = xfer_done | xfer_err;
  assign arm_only = (arm_we ? arm_mask : '0) & ~ev;
  assign ack_only = (ack_we ? ack_mask : '0) & ~ev;
  assign fr       = status[NDESC-1:0];
  assign fn       = status[2*NDESC-1:NDESC];

  AST_END_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev != '0 |=> ((fr & fn & $past(ev)) == $past(ev))); // R4
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_only != '0 |=> (((fr | fn) & $past(arm_only)) == '0)); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_only != '0 |=> ((fn & $past(ack_only)) == '0)); // R5
  AST_ACK_KEEPS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_we && ev == '0 && ack_we) |=> $stable(fr)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_we && !ack_we && ev == '0) |=> $stable(status)); // R7
endmodule

bind dma_desc_status dma_desc_status_chk #(.NDESC(NDESC)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_we(arm_we), .arm_mask(arm_mask),
  .ack_we(ack_we), .ack_mask(ack_mask), .xfer_done(xfer_done),
  .xfer_err(xfer_err), .status(status)
);

// File: tb/dma_desc_status_tb.sv
module dma_desc_status_tb;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic arm_we = 1'b0, ack_we = 1'b0;
  logic [N-1:0] arm_mask = '0, ack_mask = '0, xfer_done = '0, xfer_err = '0, irq_en = '0;
  logic [2*N-1:0] status;
  logic [N-1:0] xfer_irq;
  logic irq_any;

  int checks = 0, fails = 0, cyc = 0;
  logic [N-1:0] e_free = '1, e_fin = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  dma_desc_status #(.NDESC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_we(arm_we), .arm_mask(arm_mask),
    .ack_we(ack_we), .ack_mask(ack_mask), .xfer_done(xfer_done),
    .xfer_err(xfer_err), .irq_en(irq_en), .status(status),
    .xfer_irq(xfer_irq), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] dn, input logic [N-1:0] er, input logic aw,
                       input logic [N-1:0] am, input logic cw, input logic [N-1:0] cm,
                       input logic [N-1:0] en, input string tag);
    logic [N-1:0] ends, arms, acks;
    @(negedge clk);
    xfer_done = dn; xfer_err = er; arm_we = aw; arm_mask = am;
    ack_we = cw; ack_mask = cm; irq_en = en;
    ends = dn | er;
    arms = aw ? am : '0;
    acks = cw ? cm : '0;
    for (int i = 0; i < N; i++) begin
      if (ends[i]) begin e_free[i] = 1'b1; e_fin[i] = 1'b1; end
      else begin
        if (arms[i]) e_free[i] = 1'b0;
        if (arms[i] || acks[i]) e_fin[i] = 1'b0;
      end
    end
    @(posedge clk);
    #2;
    xfer_done = '0; xfer_err = '0; arm_we = 1'b0; ack_we = 1'b0;
    #1;
    chk({tag, " R2 status"}, 32'(status), 32'({e_fin, e_free}));
    chk("R8 xfer_irq", 32'(xfer_irq), 32'(e_fin & en));
    chk("R9 irq_any", 32'(irq_any), 32'(|(e_fin & en)));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 status during reset", 32'(status), 32'h0F);
    chk("R1 irq during reset", 32'({irq_any, xfer_irq}), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 status after release", 32'(status), 32'h0F);

    apply('0, '0, 1'b0, 4'hF, 1'b0, 4'hF, 4'hF, "R7 masks without strobe");
    apply('0, '0, 1'b1, 4'b0101, 1'b0, '0, 4'hF, "R3 arm 0,2");
    apply(4'b0001, 4'b0100, 1'b0, '0, 1'b0, '0, 4'hF, "R4 done0 err2");
    apply('0, '0, 1'b0, '0, 1'b1, 4'b0001, 4'h5, "R5 ack 0");
    apply(4'b0100, '0, 1'b1, 4'b0100, 1'b1, 4'b0100, 4'hF, "R6 end vs arm+ack");

    for (int s = 0; s < 3; s++)
      for (int d = 0; d < N; d++)
        for (int c = 0; c < 16; c++) begin
          case (s)
            0: begin apply('1, '0, 1'b0, '0, 1'b0, '0, '1, "prep");
                     apply('0, '0, 1'b0, '0, 1'b1, '1, '1, "R5 prep"); end
            1: apply('0, '0, 1'b1, '1, 1'b0, '0, '1, "R3 prep");
            default: apply('0, '1, 1'b0, '0, 1'b0, '0, '1, "R4 prep");
          endcase
          apply(c[0] ? N'(1) << d : '0, c[1] ? N'(1) << d : '0,
                c[2], c[2] ? N'(1) << d : '0,
                c[3], c[3] ? N'(1) << d : '0,
                N'(c + d), "R3/R4/R5/R6 sweep");
        end

    for (int k = 0; k < 600; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      apply(seed[31:28] & {4{seed[27] & seed[26]}}, seed[25:22] & {4{seed[21] & seed[20]}},
            seed[19], seed[18:15], seed[14], seed[13:10], seed[9:6], "R7 random mix");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule